// File: doc/BRIEF.md
# Three-Share Masked Shift-Register Cipher Core

This block encrypts a 32-bit block under an 80-bit key with a lightweight shift-register cipher, while keeping the cipher state split into three Boolean shares at all times. The caller supplies the plaintext as three shares whose XOR is the plaintext, and the masks are the caller's responsibility. The key, the key schedule and the round constant stay unshared. Each round writes one new bit into each half of each share. The nonlinear part is built from three-share AND/XOR gadgets in which every output share is formed only from the other two input shares. The round key enters only the first share.

A one-cycle start pulse in the idle state loads the three plaintext shares and the key. The core then runs one round per clock for the configured number of rounds. It raises a one-cycle done flag and holds the three ciphertext shares until the next accepted start. The controller has three states. IDLE goes to RUN when start is sampled high. RUN stays in RUN while rounds remain and goes to FIN on the clock that applies the last round. FIN goes back to IDLE unconditionally.

Top module: `mcs_masked_core`

## Requirements
- R1: After reset, done_o is 0 and all three ciphertext share outputs are zero.
- R2: Each 32-bit share is packed as an upper 13-bit half (bits 31:19) and a lower 19-bit half (bits 18:0). The upper half shifts toward its MSB and receives the new bit fb at bit 0. The lower half shifts toward its MSB and receives the new bit fa at bit 0.
- R3: Unmasked, each round computes fa = U[12]^U[7]^(U[8]&U[5])^(U[3]&c)^ka and fb = W[18]^W[7]^(W[12]&W[10])^(W[8]&W[3])^kb. Here U is the upper half, W is the lower half and c is the round-constant bit.
- R4: The key register loads key_i. Each round uses bit 0 as ka and bit 1 as kb, then shifts down by two and appends the new bits k[j]^k[j+19]^k[j+30]^k[j+67] for j = 0 (placed at bit 78) and j = 1 (placed at bit 79).
- R5: The round-constant register starts at 8'hFF. Each round uses its bit 7, then shifts left and inserts bit7^bit6^bit4^bit2 at bit 0.
- R6: For any mask values, ct0_o^ct1_o^ct2_o equals the unmasked encryption of pt0_i^pt1_i^pt2_i after 254 rounds.
- R7: With both masks zero (pt1_i = pt2_i = 0), the XOR of the output shares still equals the unmasked ciphertext.
- R8: done_o is high for exactly one cycle, in the cycle after the 254th clock edge that follows the edge accepting start.
- R9: start_i and the plaintext and key inputs are ignored while a run is in progress, including the cycle in which done_o is high.
- R10: Outside a run, the ciphertext share outputs do not change while start_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| pt0_i | input | 32 | Plaintext share 0 |
| pt1_i | input | 32 | Plaintext share 1 |
| pt2_i | input | 32 | Plaintext share 2 |
| key_i | input | 80 | Unshared key |
| ct0_o | output | 32 | Ciphertext share 0 |
| ct1_o | output | 32 | Ciphertext share 1 |
| ct2_o | output | 32 | Ciphertext share 2 |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The edge that accepts start is counted as edge 0. Rounds are applied on edges 1 through 254. done_o and the final shares become visible just after edge 254 and are sampled at the following falling edge. done_o must be low again after edge 255. The bench samples done_o at the falling edge after every rising edge of a run, so the pulse can be neither early, late nor stretched. It compares the share XOR against an arithmetic reference in the done cycle. It sweeps single-bit plaintexts and single-bit keys under random masks, adds masks-off and random cases, pokes start in the middle of runs and in the done cycle, and checks that the outputs hold for several idle cycles.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
    localparam int L1W = 13;
    localparam int L2W = 19;
    localparam int SW  = L1W + L2W;
    localparam int KW  = 80;
    localparam int NSH = 3;
    localparam int KPR = 2;
    localparam int KTAP_A = 19;
    localparam int KTAP_B = 30;
    localparam int KTAP_C = 67;
    localparam int RCW = 8;
    localparam int RC_TAP_A = 6;
    localparam int RC_TAP_B = 4;
    localparam int RC_TAP_C = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } phase_t;

    typedef struct packed {
        logic [L1W-1:0] hi;
        logic [L2W-1:0] lo;
    } share_t;
endpackage

// File: rtl/mcs_nl_share.sv
`timescale 1ns/1ps
module mcs_nl_share (
    input  logic ya_i,
    input  logic za_i,
    input  logic yb_i,
    input  logic zb_i,
    output logic t_o
);
    always_comb begin
        t_o = (ya_i & za_i) ^ (ya_i & zb_i) ^ (yb_i & za_i);
    end
endmodule

// File: rtl/mcs_share_update.sv
`timescale 1ns/1ps
module mcs_share_update
    import mcs_pkg::*;
#(
    parameter bit KEYED = 1'b0
) (
    input  share_t sa_i,
    input  share_t sb_i,
    input  logic   ka_i,
    input  logic   kb_i,
    input  logic   ir_i,
    output logic   fa_o,
    output logic   fb_o
);
    logic t_u85, t_w1210, t_w83;
    logic kx_a, kx_b;
    logic unused_bits;

    assign unused_bits = ^{sa_i, sb_i};

    mcs_nl_share u_nl_u85 (
        .ya_i(sa_i.hi[8]), .za_i(sa_i.hi[5]),
        .yb_i(sb_i.hi[8]), .zb_i(sb_i.hi[5]),
        .t_o(t_u85)
    );
    mcs_nl_share u_nl_w1210 (
        .ya_i(sa_i.lo[12]), .za_i(sa_i.lo[10]),
        .yb_i(sb_i.lo[12]), .zb_i(sb_i.lo[10]),
        .t_o(t_w1210)
    );
    mcs_nl_share u_nl_w83 (
        .ya_i(sa_i.lo[8]), .za_i(sa_i.lo[3]),
        .yb_i(sb_i.lo[8]), .zb_i(sb_i.lo[3]),
        .t_o(t_w83)
    );

    generate
        if (KEYED) begin : g_key
            assign kx_a = ka_i;
            assign kx_b = kb_i;
        end else begin : g_nokey
            assign kx_a = 1'b0;
            assign kx_b = 1'b0;
        end
    endgenerate

    always_comb begin
        fa_o = sa_i.hi[12] ^ sa_i.hi[7] ^ (ir_i & sa_i.hi[3]) ^ t_u85 ^ kx_a;
        fb_o = sa_i.lo[18] ^ sa_i.lo[7] ^ t_w1210 ^ t_w83 ^ kx_b;
    end
endmodule

// File: rtl/mcs_key_sched.sv
`timescale 1ns/1ps
module mcs_key_sched
    import mcs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [KW-1:0] key_i,
    output logic          ka_o,
    output logic          kb_o,
    output logic          ir_o
);
    logic [KW-1:0]  kr_q;
    logic [RCW-1:0] rc_q;
    logic [KPR-1:0] kfb;
    logic           rc_fb;

    generate
        for (genvar j = 0; j < KPR; j++) begin : g_kfb
            assign kfb[j] = kr_q[j] ^ kr_q[j+KTAP_A] ^ kr_q[j+KTAP_B] ^ kr_q[j+KTAP_C];
        end
    endgenerate

    assign rc_fb = rc_q[RCW-1] ^ rc_q[RC_TAP_A] ^ rc_q[RC_TAP_B] ^ rc_q[RC_TAP_C];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kr_q <= '0;
            rc_q <= '1;
        end else if (load_i) begin
            kr_q <= key_i;
            rc_q <= '1;
        end else if (step_i) begin
            kr_q <= {kfb, kr_q[KW-1:KPR]};
            rc_q <= {rc_q[RCW-2:0], rc_fb};
        end
    end

    assign ka_o = kr_q[0];
    assign kb_o = kr_q[1];
    assign ir_o = rc_q[RCW-1];
endmodule

// File: rtl/mcs_masked_core.sv
`timescale 1ns/1ps
module mcs_masked_core
    import mcs_pkg::*;
#(
    parameter int ROUNDS = 254
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [SW-1:0] pt0_i,
    input  logic [SW-1:0] pt1_i,
    input  logic [SW-1:0] pt2_i,
    input  logic [KW-1:0] key_i,
    output logic [SW-1:0] ct0_o,
    output logic [SW-1:0] ct1_o,
    output logic [SW-1:0] ct2_o,
    output logic          done_o
);
    localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

    phase_t        st_q, st_d;
    logic [RW-1:0] rnd_q;
    logic          load, step;
    logic          ka, kb, ir;
    share_t        sh_q  [NSH];
    share_t        pt_sh [NSH];
    logic          fa    [NSH];
    logic          fb    [NSH];

    assign pt_sh[0] = pt0_i;
    assign pt_sh[1] = pt1_i;
    assign pt_sh[2] = pt2_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_i) st_d = ST_RUN;
            ST_RUN:  if (rnd_q == LAST) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        load   = (st_q == ST_IDLE) && start_i;
        step   = (st_q == ST_RUN);
        done_o = (st_q == ST_FIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rnd_q <= '0;
        else if (load) rnd_q <= '0;
        else if (step) rnd_q <= rnd_q + 1'b1;
    end

    mcs_key_sched u_ks (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .key_i(key_i), .ka_o(ka), .kb_o(kb), .ir_o(ir)
    );

    generate
        for (genvar g = 0; g < NSH; g++) begin : g_share
            mcs_share_update #(.KEYED(g == 0)) u_upd (
                .sa_i(sh_q[(g+1) % NSH]),
                .sb_i(sh_q[(g+2) % NSH]),
                .ka_i(ka), .kb_i(kb), .ir_i(ir),
                .fa_o(fa[g]), .fb_o(fb[g])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_q[g] <= '0;
                end else if (load) begin
                    sh_q[g] <= pt_sh[g];
                end else if (step) begin
                    sh_q[g].hi <= {sh_q[g].hi[L1W-2:0], fb[g]};
                    sh_q[g].lo <= {sh_q[g].lo[L2W-2:0], fa[g]};
                end
            end
        end
    endgenerate

    assign ct0_o = sh_q[0];
    assign ct1_o = sh_q[1];
    assign ct2_o = sh_q[2];
endmodule

// File: rtl/mcs_masked_core_chk.sv
`timescale 1ns/1ps
module mcs_masked_core_chk
    import mcs_pkg::*;
#(
    parameter int ROUNDS = 254
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic [SW-1:0] ct0_o,
    input logic [SW-1:0] ct1_o,
    input logic [SW-1:0] ct2_o
);
    localparam int CW = $clog2(ROUNDS + 2) + 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (done_o) busy_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8 and R9: done only at the expected count of a run that was not restarted
    p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_q && cnt_q == CW'(ROUNDS)));

    // R8: single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a run never outlasts its round count
    p_run_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CW'(ROUNDS)));

    // R10: outputs hold outside a run
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start_i) |=> $stable({ct0_o, ct1_o, ct2_o}));
endmodule

bind mcs_masked_core mcs_masked_core_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .ct0_o(ct0_o), .ct1_o(ct1_o), .ct2_o(ct2_o)
);

// File: tb/sim_mcs_masked_core.sv
`timescale 1ns/1ps
module sim_mcs_masked_core;
    localparam int ROUNDS = 254;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] pt0_i = '0, pt1_i = '0, pt2_i = '0;
    logic [79:0] key_i = '0;
    logic [31:0] ct0_o, ct1_o, ct2_o;
    logic        done_o;

    int n_checks = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mcs_masked_core #(.ROUNDS(ROUNDS)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pt0_i(pt0_i), .pt1_i(pt1_i), .pt2_i(pt2_i), .key_i(key_i),
        .ct0_o(ct0_o), .ct1_o(ct1_o), .ct2_o(ct2_o), .done_o(done_o)
    );

    // unmasked reference, written from R2..R5
    function automatic logic [31:0] ref_enc(input logic [31:0] p, input logic [79:0] k_in);
        logic [12:0] u = p[31:19];
        logic [18:0] w = p[18:0];
        logic [79:0] k = k_in;
        logic [7:0]  c = 8'hFF;
        logic        fa, fb, ir;
        for (int r = 0; r < ROUNDS; r++) begin
            ir = c[7];
            fa = u[12] ^ u[7] ^ (u[8] & u[5]) ^ (u[3] & ir) ^ k[0];
            fb = w[18] ^ w[7] ^ (w[12] & w[10]) ^ (w[8] & w[3]) ^ k[1];
            u = {u[11:0], fb};
            w = {w[17:0], fa};
            k = {k[1] ^ k[20] ^ k[31] ^ k[68], k[0] ^ k[19] ^ k[30] ^ k[67], k[79:2]};
            c = {c[6:0], c[7] ^ c[6] ^ c[4] ^ c[2]};
        end
        return {u, w};
    endfunction

    task automatic check(input string tag, input bit ok, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [31:0] p, input logic [79:0] k,
                           input logic [31:0] m1, input logic [31:0] m2,
                           input bit poke, input string tag);
        logic [31:0] expv;
        int          bad_at;
        expv = ref_enc(p, k);
        bad_at = -1;
        @(negedge clk);
        pt0_i = p ^ m1 ^ m2; pt1_i = m1; pt2_i = m2; key_i = k; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        pt0_i = $urandom; pt1_i = $urandom; pt2_i = $urandom;
        key_i = {$urandom, $urandom, $urandom};
        for (int j = 1; j <= ROUNDS; j++) begin
            @(negedge clk);
            if (done_o !== (j == ROUNDS) && bad_at < 0) bad_at = j;
            if (j == ROUNDS) begin
                check({tag, " R6 share xor"}, (ct0_o ^ ct1_o ^ ct2_o) === expv,
                      96'(ct0_o ^ ct1_o ^ ct2_o), 96'(expv));
            end
            start_i = poke && (j == 100 || j == ROUNDS);
        end
        check({tag, " R8 done timing"}, bad_at < 0, 96'(bad_at), 96'(-1));
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " R8 done one cycle"}, done_o === 1'b0, 96'(done_o), 96'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [95:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset done", done_o === 1'b0, 96'(done_o), 96'(0));
        check("R1 reset shares", {ct0_o, ct1_o, ct2_o} === 96'(0), {ct0_o, ct1_o, ct2_o}, 96'(0));

        // R7: masks off, several keys and plaintexts
        run_one(32'h0, 80'h0, 32'h0, 32'h0, 1'b0, "R7 zero");
        run_one(32'hFFFF_FFFF, {80{1'b1}}, 32'h0, 32'h0, 1'b0, "R7 ones");
        run_one(32'h1234_5678, 80'h0123_4567_89AB_CDEF_0246, 32'h0, 32'h0, 1'b0, "R7 mixed");

        // R2/R3: walking plaintext bit with random masks
        for (int b = 0; b < 32; b++)
            run_one(32'h1 << b, 80'h5A5A_0F0F_3C3C_9696_A5A5, $urandom, $urandom, 1'b0, "R2 R3 walk pt");

        // R4: walking key bit with random masks
        for (int b = 0; b < 80; b++)
            run_one(32'hC0DE_F00D, 80'h1 << b, $urandom, $urandom, 1'b0, "R4 walk key");

        // R5: round constant gates upper bit 3
        run_one(32'h1 << (19 + 3), 80'h0, $urandom, $urandom, 1'b0, "R5 const");
        run_one(32'h1 << (19 + 3) | 32'h1 << (19 + 8), 80'h0, 32'h0, 32'h0, 1'b0, "R5 const off");

        // R6: random
        for (int n = 0; n < 16; n++)
            run_one($urandom, {$urandom, $urandom, $urandom}, $urandom, $urandom, 1'b0, "R6 random");

        // R9: start pokes during a run and in the done cycle
        for (int n = 0; n < 4; n++)
            run_one($urandom, {$urandom, $urandom, $urandom}, $urandom, $urandom, 1'b1, "R9 poke");

        // R10: outputs hold while idle with inputs changing
        held = {ct0_o, ct1_o, ct2_o};
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            pt0_i = $urandom; pt1_i = $urandom; pt2_i = $urandom;
            key_i = {$urandom, $urandom, $urandom};
        end
        @(negedge clk);
        check("R10 hold", {ct0_o, ct1_o, ct2_o} === held, {ct0_o, ct1_o, ct2_o}, held);
        check("R10 no done", done_o === 1'b0, 96'(done_o), 96'(0));

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule